// File: doc/BRIEF.md
# Serial Frame LED Dimming Controller

This block sets the brightness of six LED channels. In serial mode, three of its four dimming inputs act as a small serial link. They carry a data line, a shift clock and a frame-end strobe. Each frame holds four 8-bit duty bytes, and each byte is shifted in least significant bit first. A falling edge on the strobe loads the bytes as the new duties. Four 8-bit PWM generators turn the duties into active-high group signals. The six channel outputs are fanned out from these four groups.

In direct mode, the four dimming inputs are driven by external PWM signals. Each input is passed straight to its group, and from there to its channels. All serial inputs are asynchronous to the system clock. They pass through a two-flop synchronizer before any edge is detected.

Top module: `dim_frame_ctrl`

## Requirements
- R1: In a frame, bit i of the stream goes to byte i/8, at bit position i%8 (least significant bit first). Byte 0 sets group A, byte 1 sets group B, byte 2 sets group C and byte 3 sets group D.
- R2: One data bit is captured on each rising edge of the serial clock (dimIn[1]), from dimIn[0]. A change of dimIn[0] while the serial clock is high and after its rise has no effect.
- R3: A falling edge on dimIn[2] that follows exactly 32 captured bits commits the frame. The new duties are visible at the outputs within 300 system clocks.
- R4: A falling edge on dimIn[2] after fewer or more than 32 bits discards the frame. The active duties are kept. The bit count restarts, so the next full frame commits normally.
- R5: Over any 256 consecutive clocks, a group with duty d is high for exactly d clocks. Duty 0 gives a constant low, and duty 255 gives 255 high clocks out of 256.
- R6: A new duty takes effect only at the start of a PWM period. A group output rises at most once per 256-clock period.
- R7: chanOut[0] and chanOut[1] follow group A. chanOut[2] and chanOut[3] follow group B. chanOut[4] follows group C, and chanOut[5] follows group D.
- R8: When modeDirect is 1, group k follows dimIn[k] without any clock delay. Leaving direct mode keeps the duties that were active before.
- R9: In serial mode, dimIn[3] has no effect on any output.
- R10: While reset is asserted, and after reset until the first committed frame, all channel outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeDirect | input | 1 | 1: direct PWM pass-through, 0: serial frame mode |
| dimIn | input | 4 | Direct mode: group A..D PWM. Serial mode: [0] data, [1] shift clock, [2] frame-end strobe, [3] unused |
| chanOut | output | 6 | Active-high channel dimming outputs |

## Verification
In direct mode there is no clock delay, so the channel outputs are checked a fraction of a nanosecond after each input pattern is applied. In serial mode, a serial-clock rise takes three system clocks to reach the shift register. A strobe fall takes three system clocks to commit the frame. The committed duty then waits up to 256 clocks for the next period boundary. For this reason, every duty check waits 300 clocks after the strobe falls. It then counts high cycles over a 256-clock window sampled on falling edges, and that count equals the duty whatever the window's phase. The bench sweeps all 256 duty values across the four groups. It also checks short and long frames, activity on dimIn[3], and the return from direct mode.

// File: rtl/dimPkg.sv
package dimPkg;
  localparam int NUM_GRP = 4;
  localparam int NUM_CH  = 6;

  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic commit;
  } dimCtl_t;
endpackage

// File: rtl/dim_sync.sv
module dim_sync #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/dim_serial_ctrl.sv
module dim_serial_ctrl
  import dimPkg::*;
#(
  parameter int DUTY_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeDirect,
  input  logic [2:0] serIn,
  output dimCtl_t    ctl
);
  localparam int FRAME_BITS = NUM_GRP * DUTY_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(FRAME_BITS + 1);

  logic [2:0]       serSync;
  logic             prevSclk;
  logic             prevEof;
  logic             sclkRise;
  logic             eofFall;
  logic [CNT_W-1:0] bitCnt;

  dim_sync #(.WIDTH(3), .DEPTH(SYNC_DEPTH)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .din (serIn),
    .dout(serSync)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      prevSclk <= 1'b0;
      prevEof  <= 1'b0;
    end else begin
      prevSclk <= serSync[1];
      prevEof  <= serSync[2];
    end

  assign sclkRise = serSync[1] & ~prevSclk;
  assign eofFall  = ~serSync[2] & prevEof;

  always_comb begin
    ctl.shiftEn = !modeDirect && sclkRise;
    ctl.bitVal  = serSync[0];
    ctl.commit  = !modeDirect && eofFall && (bitCnt == FULL_CNT);
  end

  // counter saturates one past a full frame so long frames are rejected
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                          bitCnt <= '0;
    else if (modeDirect || eofFall)     bitCnt <= '0;
    else if (sclkRise && bitCnt != OVER_CNT) bitCnt <= bitCnt + 1'b1;
endmodule

// File: rtl/dim_datapath.sv
module dim_datapath
  import dimPkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeDirect,
  input  logic [NUM_GRP-1:0] dimIn,
  input  dimCtl_t           ctl,
  output logic [NUM_CH-1:0] chanOut
);
  localparam int FRAME_BITS = NUM_GRP * DUTY_W;
  localparam logic [DUTY_W-1:0] CNT_LAST = '1;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] pendDuty;
  logic [FRAME_BITS-1:0] actDuty;
  logic [DUTY_W-1:0]     pwmCnt;
  logic [NUM_GRP-1:0]    grpPwm;
  logic [NUM_GRP-1:0]    grpOut;

  // bits enter at the top, so the first bit ends at position 0
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= {ctl.bitVal, shiftReg[FRAME_BITS-1:1]};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           pendDuty <= '0;
    else if (ctl.commit) pendDuty <= shiftReg;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pwmCnt <= '0;
    else       pwmCnt <= pwmCnt + 1'b1;

  // load on the last count so the new value governs a whole period
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  actDuty <= '0;
    else if (pwmCnt == CNT_LAST) actDuty <= pendDuty;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pwm
    assign grpPwm[g] = pwmCnt < actDuty[g*DUTY_W +: DUTY_W];
  end

  assign grpOut  = modeDirect ? dimIn : grpPwm;
  assign chanOut = {grpOut[3], grpOut[2], grpOut[1], grpOut[1], grpOut[0], grpOut[0]};
endmodule

// File: rtl/dim_frame_ctrl.sv
module dim_frame_ctrl
  import dimPkg::*;
#(
  parameter int DUTY_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeDirect,
  input  logic [3:0] dimIn,
  output logic [5:0] chanOut
);
  dimCtl_t ctl;

  dim_serial_ctrl #(.DUTY_W(DUTY_W), .SYNC_DEPTH(SYNC_DEPTH)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeDirect(modeDirect),
    .serIn     (dimIn[2:0]),
    .ctl       (ctl)
  );

  dim_datapath #(.DUTY_W(DUTY_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .modeDirect(modeDirect),
    .dimIn     (dimIn),
    .ctl       (ctl),
    .chanOut   (chanOut)
  );
endmodule

// File: rtl/dim_frame_chk.sv
module dim_frame_chk
  import dimPkg::*;
#(
  parameter int DUTY_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      modeDirect,
  input dimCtl_t                   ctl,
  input logic [NUM_GRP*DUTY_W-1:0] shiftReg,
  input logic [NUM_GRP*DUTY_W-1:0] pendDuty,
  input logic [NUM_GRP*DUTY_W-1:0] actDuty,
  input logic [DUTY_W-1:0]         pwmCnt,
  input logic [NUM_CH-1:0]         chanOut
);
  // R3
  commit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> pendDuty == $past(shiftReg));

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(pendDuty));

  // R6
  duty_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actDuty) |-> pwmCnt == '0);

  // R6
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeDirect && !$past(modeDirect) && $rose(chanOut[0])) |-> pwmCnt == '0);

  // R7
  fanout_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanOut[0] == chanOut[1] && chanOut[2] == chanOut[3]);

  // R5
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeDirect && actDuty[DUTY_W-1:0] == '0) |-> !chanOut[0]);
endmodule

bind dim_datapath dim_frame_chk #(.DUTY_W(DUTY_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeDirect(modeDirect),
  .ctl       (ctl),
  .shiftReg  (shiftReg),
  .pendDuty  (pendDuty),
  .actDuty   (actDuty),
  .pwmCnt    (pwmCnt),
  .chanOut   (chanOut)
);

// File: tb/test_dim_frame_ctrl.sv
module test_dim_frame_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeDirect = 1'b0;
  logic [3:0] dimIn = 4'b0100;
  logic [5:0] chanOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int hiCnt [6];
  int rises;
  int grpOf [6] = '{0, 0, 1, 1, 2, 3};

  always #5 clk = ~clk;

  dim_frame_ctrl i_dim_frame_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeDirect(modeDirect),
    .dimIn     (dimIn),
    .chanOut   (chanOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    dimIn[0] = b;
    waitCyc(2);
    dimIn[1] = 1'b1;
    waitCyc(4);
    dimIn[0] = ~b;   // moves while clock is high: must not be captured
    waitCyc(2);
    dimIn[1] = 1'b0;
    waitCyc(2);
  endtask

  task automatic sendFrame(input logic [31:0] word, input int nBits);
    for (int i = 0; i < nBits; i++) sendBit(word[i % 32]);
    dimIn[2] = 1'b0;
    waitCyc(4);
    dimIn[2] = 1'b1;
    waitCyc(300);
  endtask

  task automatic measure(input bit toggle3);
    bit prev;
    for (int c = 0; c < 6; c++) hiCnt[c] = 0;
    rises = 0;
    @(negedge clk);
    prev = chanOut[0];
    for (int t = 0; t < 256; t++) begin
      @(negedge clk);
      if (toggle3) dimIn[3] = ~dimIn[3];
      for (int c = 0; c < 6; c++) hiCnt[c] += int'(chanOut[c]);
      if (chanOut[0] && !prev) rises++;
      prev = chanOut[0];
    end
  endtask

  task automatic checkDuties(input logic [31:0] word, input string req);
    for (int c = 0; c < 6; c++)
      chk(hiCnt[c] == int'(word[grpOf[c]*8 +: 8]), req, hiCnt[c], int'(word[grpOf[c]*8 +: 8]));
  endtask

  initial begin
    logic [31:0] word;
    logic [31:0] lastWord;
    logic [5:0]  expCh;
    waitCyc(3);
    // R10: low during reset
    chk(chanOut == 6'b0, "R10 in reset", chanOut, 0);
    rstN = 1'b1;
    waitCyc(2);
    measure(1'b0);
    checkDuties(32'h0, "R10 after reset");

    // R1 R2 R3 R5 R6 R7 R9: sweep every duty value over the four groups
    for (int k = 0; k < 64; k++) begin
      word = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
      sendFrame(word, 32);
      measure(k[0]);
      checkDuties(word, k[0] ? "R9 R1 R3 R5 R7 sweep" : "R1 R2 R3 R5 R7 sweep");
      chk(rises <= 1, "R6 rises per period", rises, 1);
    end
    lastWord = word;

    // R5 extremes on group A and D
    word = {8'd255, 8'd1, 8'd254, 8'd0};
    sendFrame(word, 32);
    measure(1'b1);
    checkDuties(word, "R5 extremes");
    lastWord = word;

    // R4: short and long frames are dropped
    sendFrame(32'hFFFF_FFFF, 31);
    measure(1'b0);
    checkDuties(lastWord, "R4 short frame");
    sendFrame(32'h1234_5678, 33);
    measure(1'b0);
    checkDuties(lastWord, "R4 long frame");
    word = 32'h80_40_C0_10;
    sendFrame(word, 32);
    measure(1'b0);
    checkDuties(word, "R4 recovery frame");
    lastWord = word;

    // R8: direct pass-through for every pattern
    modeDirect = 1'b1;
    for (int p = 0; p < 16; p++) begin
      dimIn = 4'(p);
      #1;
      expCh = {dimIn[3], dimIn[2], dimIn[1], dimIn[1], dimIn[0], dimIn[0]};
      chk(chanOut == expCh, "R8 R7 direct", chanOut, expCh);
      waitCyc(1);
    end
    dimIn = 4'b0100;
    waitCyc(5);
    modeDirect = 1'b0;
    waitCyc(2);
    measure(1'b0);
    checkDuties(lastWord, "R8 duties kept");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule